// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by walking a two-level page table held in memory, with 4 KB pages. A request carries the address, whether the access is a write, and whether it comes from user mode. The block reads the directory entry and then the table entry over a word-wide request/acknowledge memory port. It checks the present, writable and user-allowed bits at both levels and returns either the physical address or a fault code.

On a successful walk the block writes the accessed flag back into both entries. On a write it also writes the dirty flag into the table entry. An entry is rewritten only when one of its bits actually changes. A paging-enable input allows translation to be bypassed. Only one walk runs at a time, and a busy flag covers the whole walk.

Top module: `pt_walker`

## Requirements
- R1: When `pg_en` is low at acceptance, `done` rises one cycle after acceptance with `pa` equal to `req_vaddr` and `fault` low, and no memory request is made.
- R2: The directory entry is read from `{dir_base[31:12], va[31:22], 2'b00}`. The table entry is then read from `{pde[31:12], va[21:12], 2'b00}`. Every memory address is word aligned.
- R3: A successful walk returns `pa = {pte[31:12], va[11:0]}`, with `fault` low and `fault_code` 2'b00.
- R4: A directory entry with bit 0 (present) clear ends the walk with `fault_code` 2'b01, and no table read is made. A table entry with bit 0 clear ends the walk with `fault_code` 2'b10.
- R5: A write access ends with `fault_code` 2'b11 when bit 1 (writable) of the directory entry AND bit 1 of the table entry is 0.
- R6: A user access ends with `fault_code` 2'b11 when bit 2 (user allowed) of the directory entry AND bit 2 of the table entry is 0. Supervisor accesses ignore bit 2.
- R7: After a successful walk, bit 5 (accessed) is set in both entries in memory. Each entry is written only if its value changes. A faulted walk writes nothing.
- R8: A successful write access also sets bit 6 (dirty) in the table entry. The directory entry's bit 6 is never changed.
- R9: Write-backs keep every other bit of the entry. The directory write comes before the table write.
- R10: After reset `busy`, `done` and `mem_req` are low. `busy` is high from the cycle after acceptance through the cycle of `done`. `done` is a one-cycle pulse, and `fault` is high only together with `done`.
- R11: A request presented while `busy` is high is ignored. It does not change the walk in progress and does not start a second walk.
- R12: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until the cycle in which `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pg_en | input | 1 | Translation enable, sampled at acceptance |
| dir_base | input | 32 | Directory physical base (bits 31:12 used) |
| req_valid | input | 1 | Translation request, taken when not busy |
| req_vaddr | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a fault (with done) |
| fault_code | output | 2 | 01 directory absent, 10 table absent, 11 protection |
| pa | output | 32 | Physical address (valid with done, no fault) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
Checks run on every cycle for the memory port: requests must stay held and stable until acknowledged, addresses must be word aligned, and the port must be silent while idle. They also check the shape of the busy/done/fault handshake, that every write-back carries the accessed flag, and that a completed translation keeps the page offset. Only the bench's scenarios can show the things that depend on table contents. These are the exact entry addresses, which fault code each permission mix produces, and whether a write-back was skipped because nothing changed. The order of the directory and table writes, dirty marking on writes, and ignoring requests during a walk are also shown there. The bench's reference model predicts each memory access and result from its own copy of memory.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int AW   = 32,
  parameter int OFFW = 12,
  parameter int IDXW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pg_en,
  input  logic [AW-1:0] dir_base,
  input  logic          req_valid,
  input  logic [AW-1:0] req_vaddr,
  input  logic          req_write,
  input  logic          req_user,
  output logic          busy,
  output logic          done,
  output logic          fault,
  output logic [1:0]    fault_code,
  output logic [AW-1:0] pa,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata
);
  localparam int FRW = AW - OFFW;
  localparam int B_P = 0, B_RW = 1, B_US = 2, B_A = 5, B_D = 6;

  typedef enum logic [2:0] {S_IDLE, S_RDIR, S_RTBL, S_WDIR, S_WTBL, S_FIN} st_t;
  st_t st;

  logic [AW-1:0]  va_q, pde_q, pte_q;
  logic [FRW-1:0] base_q;
  logic           wr_q, usr_q;
  logic [1:0]     code_q;
  logic [AW-1:0]  pa_q;

  wire [AW-1:0] dir_addr = {base_q, va_q[AW-1 -: IDXW], 2'b00};
  wire [AW-1:0] tbl_addr = {pde_q[AW-1:OFFW], va_q[OFFW +: IDXW], 2'b00};
  wire [AW-1:0] pde_new  = pde_q | (AW'(1) << B_A);
  wire [AW-1:0] pte_new  = pte_q | (AW'(1) << B_A) | (AW'(wr_q) << B_D);
  wire          pte_chg  = (pte_new != pte_q);

  wire          rd_rw  = pde_q[B_RW] & mem_rdata[B_RW];
  wire          rd_us  = pde_q[B_US] & mem_rdata[B_US];
  wire          prot   = (wr_q & ~rd_rw) | (usr_q & ~rd_us);
  wire          rd_chg = ~mem_rdata[B_A] | (wr_q & ~mem_rdata[B_D]);

  assign busy       = (st != S_IDLE);
  assign done       = (st == S_FIN);
  assign fault      = done & (code_q != 2'b00);
  assign fault_code = code_q;
  assign pa         = pa_q;

  assign mem_req   = (st == S_RDIR) | (st == S_RTBL) | (st == S_WDIR) | (st == S_WTBL);
  assign mem_we    = (st == S_WDIR) | (st == S_WTBL);
  assign mem_addr  = ((st == S_RDIR) | (st == S_WDIR)) ? dir_addr : tbl_addr;
  assign mem_wdata = (st == S_WDIR) ? pde_new : pte_new;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      va_q   <= '0;
      pde_q  <= '0;
      pte_q  <= '0;
      base_q <= '0;
      wr_q   <= 1'b0;
      usr_q  <= 1'b0;
      code_q <= 2'b00;
      pa_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          wr_q   <= req_write;
          usr_q  <= req_user;
          base_q <= dir_base[AW-1:OFFW];
          code_q <= 2'b00;
          if (pg_en) st <= S_RDIR;
          else begin
            pa_q <= req_vaddr;
            st   <= S_FIN;
          end
        end
        S_RDIR: if (mem_ack) begin
          pde_q <= mem_rdata;
          if (!mem_rdata[B_P]) begin
            code_q <= 2'b01;
            st     <= S_FIN;
          end else st <= S_RTBL;
        end
        S_RTBL: if (mem_ack) begin
          pte_q <= mem_rdata;
          if (!mem_rdata[B_P]) begin
            code_q <= 2'b10;
            st     <= S_FIN;
          end else if (prot) begin
            code_q <= 2'b11;
            st     <= S_FIN;
          end else begin
            pa_q <= {mem_rdata[AW-1:OFFW], va_q[OFFW-1:0]};
            if (!pde_q[B_A]) st <= S_WDIR;
            else if (rd_chg) st <= S_WTBL;
            else st <= S_FIN;
          end
        end
        S_WDIR: if (mem_ack) st <= pte_chg ? S_WTBL : S_FIN;
        S_WTBL: if (mem_ack) st <= S_FIN;
        S_FIN:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module pt_walker_chk #(parameter int AW = 32) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          fault,
  input logic [1:0]    fault_code,
  input logic [AW-1:0] pa,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] mem_wdata,
  input logic          mem_ack,
  input logic [AW-1:0] va_q
);
  AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);                        // R10
  AST_DONE_BUSY:    assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);                         // R10
  AST_FAULT_DONE:   assert property (@(posedge clk) disable iff (!rst_n) fault |-> done && fault_code != 2'b00); // R10
  AST_WALK_HOLDS:   assert property (@(posedge clk) disable iff (!rst_n) busy && !done |=> busy);                // R11
  AST_REQ_HOLD:     assert property (@(posedge clk) disable iff (!rst_n)
                      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R12
  AST_ALIGNED:      assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> mem_addr[1:0] == 2'b00);   // R2
  AST_IDLE_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mem_req);                   // R10
  AST_WB_ACCESSED:  assert property (@(posedge clk) disable iff (!rst_n) mem_req && mem_we |-> mem_wdata[5]);   // R7
  AST_OFFSET_KEPT:  assert property (@(posedge clk) disable iff (!rst_n) done && !fault |-> pa[11:0] == va_q[11:0]); // R3
endmodule

bind pt_walker pt_walker_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fault(fault),
  .fault_code(fault_code), .pa(pa), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .va_q(va_q)
);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic clk = 0, rst_n = 0;
  logic pg_en = 1, req_valid = 0, req_write = 0, req_user = 0, mem_ack = 0;
  logic [31:0] dir_base = 32'h0001_0000, req_vaddr = 0, mem_rdata = 0;
  logic busy, done, fault, mem_req, mem_we;
  logic [1:0] fault_code;
  logic [31:0] pa, mem_addr, mem_wdata;

  always #2.5 clk = ~clk;

  pt_walker u0 (.*);

  int checks = 0, fails = 0;
  bit [31:0] mem [bit [31:0]];
  bit [31:0] q_addr[$], q_wd[$];
  bit        q_we[$];

  function automatic bit [31:0] rd(bit [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic bit [31:0] mkva(int d, int t, int o);
    return {d[9:0], t[9:0], o[11:0]};
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  initial begin : responder
    int lat;
    lat = 0;
    forever begin
      @(negedge clk);
      mem_ack = 0;
      if (rst_n && mem_req) begin
        if (lat == 0) begin
          if (q_addr.size() == 0) chk(0, "R4", "unexpected memory access", mem_addr, 0);
          else begin
            chk(mem_addr == q_addr[0], "R2", "access address", mem_addr, q_addr[0]);
            chk(mem_we == q_we[0], "R7", "access kind", 32'(mem_we), 32'(q_we[0]));
            if (q_we[0]) chk(mem_wdata == q_wd[0], "R8", "write-back data", mem_wdata, q_wd[0]);
            void'(q_addr.pop_front()); void'(q_we.pop_front()); void'(q_wd.pop_front());
          end
          if (mem_we) mem[mem_addr] = mem_wdata;
          else mem_rdata = rd(mem_addr);
          mem_ack = 1;
          lat = $urandom_range(0, 2);
        end else lat--;
      end
    end
  end

  task automatic walk(bit [31:0] va, bit w, bit u, bit pg, string tag, bit ign = 0);
    bit [31:0] da, ta, pde, pte, npde, npte, epa;
    bit [1:0] ec;
    int n;
    epa = va; ec = 0;
    if (pg) begin
      da = {dir_base[31:12], va[31:22], 2'b00};
      pde = rd(da);
      q_addr.push_back(da); q_we.push_back(0); q_wd.push_back(0);
      if (!pde[0]) ec = 2'b01;
      else begin
        ta = {pde[31:12], va[21:12], 2'b00};
        pte = rd(ta);
        q_addr.push_back(ta); q_we.push_back(0); q_wd.push_back(0);
        if (!pte[0]) ec = 2'b10;
        else if ((w && !(pde[1] & pte[1])) || (u && !(pde[2] & pte[2]))) ec = 2'b11;
        else begin
          epa = {pte[31:12], va[11:0]};
          npde = pde | 32'h20;
          npte = pte | 32'h20 | (w ? 32'h40 : 0);
          if (npde != pde) begin q_addr.push_back(da); q_we.push_back(1); q_wd.push_back(npde); end
          if (npte != pte) begin q_addr.push_back(ta); q_we.push_back(1); q_wd.push_back(npte); end
        end
      end
    end
    @(negedge clk);
    req_vaddr = va; req_write = w; req_user = u; pg_en = pg; req_valid = 1;
    @(negedge clk);
    req_valid = ign;
    if (ign) begin req_vaddr = mkva(4, 0, 0); pg_en = 1; end
    n = 0;
    while (!done && n < 300) begin
      chk(busy, "R10", "busy during walk", 32'(busy), 1);
      @(negedge clk); n++;
    end
    req_valid = 0;
    chk(done, tag, "walk completion", 32'(done), 1);
    chk(fault_code == ec, tag, "fault code", 32'(fault_code), 32'(ec));
    chk(fault == (ec != 0), tag, "fault flag", 32'(fault), 32'(ec != 0));
    if (ec == 0) chk(pa == epa, tag, "physical address", pa, epa);
    chk(q_addr.size() == 0, "R9", "missing memory accesses", q_addr.size(), 0);
    q_addr.delete(); q_we.delete(); q_wd.delete();
    repeat (ign ? 3 : 1) begin
      @(negedge clk);
      chk(!busy && !done, ign ? "R11" : "R10", "idle after done", {busy, done}, 0);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog expired: actual %h expected %h", 32'd0, 32'd1);
    finish_up();
  end

  initial begin
    mem[32'h0001_0004] = 32'h0002_0007;
    mem[32'h0002_0014] = 32'h0AB0_0007;
    mem[32'h0002_0018] = 32'h0CD0_0005;
    mem[32'h0002_001C] = 32'h0EF0_0003;
    mem[32'h0001_0008] = 32'h0003_0005;
    mem[32'h0003_0000] = 32'h0110_0E07;
    mem[32'h0001_000C] = 32'h0004_0003;
    mem[32'h0004_0000] = 32'h0220_0007;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req, "R10", "reset state", {busy, done, mem_req}, 0);
    rst_n = 1;
    @(negedge clk);
    walk(32'hDEAD_BEEF, 1, 1, 0, "R1");
    walk(mkva(1, 5, 12'h123), 0, 0, 1, "R3");
    walk(mkva(1, 5, 12'h456), 0, 1, 1, "R7");
    walk(mkva(1, 5, 12'h789), 1, 1, 1, "R8");
    walk(mkva(1, 6, 12'h010), 1, 1, 1, "R5");
    walk(mkva(1, 6, 12'h020), 0, 1, 1, "R6");
    walk(mkva(1, 7, 12'h030), 0, 1, 1, "R6");
    walk(mkva(1, 7, 12'h040), 1, 0, 1, "R6");
    walk(mkva(1, 8, 12'h050), 0, 0, 1, "R4");
    walk(mkva(9, 0, 12'h060), 0, 0, 1, "R4");
    walk(mkva(2, 0, 12'h070), 1, 0, 1, "R5");
    walk(mkva(2, 0, 12'h080), 0, 1, 1, "R9");
    walk(mkva(3, 0, 12'h090), 0, 1, 1, "R6");
    walk(mkva(3, 0, 12'h0A0), 1, 0, 1, "R9");
    walk(mkva(1, 5, 12'hABC), 0, 0, 1, "R11", 1);
    walk(32'h1234_5678, 0, 0, 0, "R1");
    finish_up();
  end
endmodule